// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a single-cycle processor and drives it as the fetch address of a word-addressed instruction memory. The memory sits outside the block. Its read word comes back on an input port and leaves the block unchanged as the fetched instruction, in the same cycle.

On every rising clock edge the counter takes one of two values. The sequential value is the current PC plus four. The branch value is that same PC plus four with a signed 16-bit word offset added. The offset is sign-extended and multiplied by four before the add.

The branch value is chosen only when two conditions hold together. The decoder must assert the branch select, and the datapath comparator must report that the two register operands are equal. A synchronous reset returns the counter to address zero.

Top module: `fetch_npc`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0x00000000 at that edge.
- R2: When `br_sel` is 0 and `eq_flag` is 0, the next PC equals the current PC plus 4.
- R3: When `br_sel` and `eq_flag` are both 1, the next PC equals PC + 4 + (imm16 sign-extended from bit 15, then multiplied by 4).
- R4: When `br_sel` is 1 and `eq_flag` is 0, the next PC is PC + 4, whatever value `imm16` carries.
- R5: When `eq_flag` is 1 and `br_sel` is 0, the next PC is PC + 4, whatever value `imm16` carries.
- R6: An immediate with bit 15 set gives a taken branch whose target lies below PC + 4.
- R7: Bits 1:0 of the PC read 00 in every cycle.
- R8: `instr` equals `imem_data` in the same cycle, so the fetched word is the memory word at the current PC.
- R9: PC arithmetic wraps modulo 2^32. The sequential step from 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Branch select from the decoder |
| eq_flag | input | 1 | Operand equality flag from the datapath |
| imm16 | input | 16 | Signed branch word offset |
| imem_data | input | 32 | Word read from instruction memory at `pc` |
| pc | output | 32 | Current program counter, used as the fetch address |
| instr | output | 32 | Fetched instruction word |

## Verification
The next-PC choice is driven with all four combinations of branch select and equality flag.

Only the combination with both inputs high may move the PC off the sequential path. In the other three combinations the immediate carries a large nonzero value, so a stray offset would show up as a wrong PC.

Taken branches use a positive offset, a negative offset and a zero offset. The zero case tells a taken branch apart from a step of four only if the offset has been added in the wrong place. The negative cases catch a missing sign extension.

One backward branch from address zero lands on 0xFFFFFFFC, and the sequential step after it checks the wrap to zero. At every step the bench compares the fetched word with its own memory image.

// File: rtl/fetch_npc.sv
`timescale 1ns/1ps
module fetch_npc #(
  parameter int PC_W = 32,
  parameter int IMM_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_sel,
  input  logic             eq_flag,
  input  logic [IMM_W-1:0] imm16,
  input  logic [PC_W-1:0]  imem_data,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  instr
);
  localparam int EXT_W = PC_W - IMM_W - 2;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] br_ofs;
  logic [PC_W-1:0] br_pc;
  logic            take;

  assign take   = br_sel & eq_flag;
  assign seq_pc = pc_q + PC_W'(4);
  assign br_ofs = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
  assign br_pc  = seq_pc + br_ofs;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= take ? br_pc : seq_pc;
  end

  assign pc    = pc_q;
  assign instr = imem_data;
endmodule

// File: rtl/fetch_npc_chk.sv
`timescale 1ns/1ps
module fetch_npc_chk #(
  parameter int PC_W = 32,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             br_sel,
  input logic             eq_flag,
  input logic [IMM_W-1:0] imm16,
  input logic [PC_W-1:0]  imem_data,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  instr
);
  localparam int EXT_W = PC_W - IMM_W - 2;

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (pc == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_sel && !eq_flag) |=> (pc == $past(pc) + PC_W'(4)));

  // R3
  taken_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel && eq_flag) |=>
      (pc == $past(pc) + PC_W'(4) + {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00}));

  // R4
  sel_only_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel && !eq_flag) |=> (pc == $past(pc) + PC_W'(4)));

  // R5
  eq_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_sel && eq_flag) |=> (pc == $past(pc) + PC_W'(4)));

  // R7
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R8
  instr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    instr == imem_data);
endmodule

bind fetch_npc fetch_npc_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag), .imm16(imm16),
  .imem_data(imem_data), .pc(pc), .instr(instr)
);

// File: tb/test_fetch_npc.sv
`timescale 1ns/1ps
module test_fetch_npc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        eq_flag = 1'b0;
  logic [15:0] imm16 = '0;
  logic [31:0] imem_data;
  logic [31:0] pc;
  logic [31:0] instr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_pc = '0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [7:0] w;
    w = a[9:2];
    return {w, ~w, w ^ 8'h5A, 8'hC3} ^ 32'h1234_0000;
  endfunction

  assign imem_data = mem_word(pc);

  fetch_npc i_fetch_npc (
    .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag), .imm16(imm16),
    .imem_data(imem_data), .pc(pc), .instr(instr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic e, input logic [15:0] im, input string tag);
    br_sel = s; eq_flag = e; imm16 = im;
    @(posedge clk);
    if (s && e) exp_pc = exp_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
    else        exp_pc = exp_pc + 32'd4;
    @(negedge clk);
    chk(pc == exp_pc, tag, pc, exp_pc);
    chk(pc[1:0] == 2'b00, "R7 align", {30'd0, pc[1:0]}, 32'd0);
    chk(instr == mem_word(exp_pc), "R8 fetch", instr, mem_word(exp_pc));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    exp_pc = '0;
    chk(pc == 32'd0, "R1 reset", pc, 32'd0);
    chk(instr == mem_word(32'd0), "R8 fetch at reset", instr, mem_word(32'd0));
    rst = 1'b0;
  endtask

  task automatic t_seq();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 16'h0000, "R2 sequential");
  endtask

  task automatic t_taken_fwd();
    step(1'b1, 1'b1, 16'h0010, "R3 taken forward");
    step(1'b1, 1'b1, 16'h0000, "R3 taken zero offset");
  endtask

  task automatic t_taken_back();
    step(1'b1, 1'b1, 16'hFFF8, "R6 taken backward");
    step(1'b1, 1'b1, 16'h8000, "R6 most negative offset");
  endtask

  task automatic t_sel_no_eq();
    step(1'b1, 1'b0, 16'h7FFF, "R4 select without equal");
    step(1'b1, 1'b0, 16'h8001, "R4 select without equal neg imm");
  endtask

  task automatic t_eq_no_sel();
    step(1'b0, 1'b1, 16'h1234, "R5 equal without select");
    step(1'b0, 1'b0, 16'hFFFF, "R2 imm ignored on sequential");
  endtask

  task automatic t_wrap();
    t_reset();
    step(1'b1, 1'b1, 16'hFFFE, "R6 backward from zero");
    chk(pc == 32'hFFFF_FFFC, "R9 below zero", pc, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 16'h0000, "R9 wrap to zero");
    chk(pc == 32'd0, "R9 wrap value", pc, 32'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_seq();
    t_taken_fwd();
    t_taken_back();
    t_sel_no_eq();
    t_eq_no_sel();
    t_wrap();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(pc == 32'd0, "R1 reset mid-run", pc, 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule